// File: doc/BRIEF.md
# Serial Majority Vote Counter

This block decides whether most of the bits in a 13-bit word are ones, for a word that arrives one bit per clock. While the start control is high, each rising clock edge accepts one serial bit. The block counts how many bits it has accepted and how many of them were ones. After the thirteenth bit it raises a valid flag. It then shows the majority value: 1 when seven or more of the bits were ones, and 0 otherwise.

Taking start low clears both counters on the next clock edge. A new word begins on the first edge at which start is high again. The vote is spread over thirteen cycles using small running counters, so no wide parallel adder tree is needed. This keeps the logic depth per cycle very short, which suits a 20 ns clock. The start control must already be synchronous to the clock.

Top module: `serial_majority`

## Requirements
- R1: While rst_n is low, valid_o and result_o are both 0, and both stay 0 on the first edge after release while start_i is low.
- R2: A rising edge with start_i low clears the bit-position and ones counts, so valid_o and result_o read 0 afterwards.
- R3: Each rising edge with start_i high accepts bit_i as the next bit of the word. valid_o is 0 after 12 accepted bits and becomes 1 right after the edge that accepts the 13th.
- R4: Once valid_o is 1, result_o is 1 exactly when more than 6 of the 13 accepted bits were 1. Words with exactly 6 ones give 0 and words with exactly 7 ones give 1.
- R5: After the 13th bit, further edges with start_i high leave valid_o at 1 and result_o unchanged, whatever bit_i carries.
- R6: result_o is 0 whenever valid_o is 0.
- R7: A word that follows a single clearing edge is voted on its own bits alone, with nothing carried over from the previous word.
- R8: Values on bit_i at edges where start_i is low have no effect on the next word's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | High to accept bits; low clears the counts |
| bit_i | input | 1 | Serial data bit, one per clock edge |
| result_o | output | 1 | Majority value of the finished word |
| valid_o | output | 1 | High once 13 bits have been accepted |

## Verification
The hardest cases to reach are the ones at the edge of the threshold. A word must carry exactly six or exactly seven ones, and the thirteenth bit must be the one that tips the decision. The stimulus builds these words directly, including ones whose deciding one arrives last. It also adds random words, with extra bits after the thirteenth and junk bits during the clearing gaps. This shows that the count is frozen once full and is not disturbed by bits sent while start is low.

// File: rtl/serial_majority_pkg.sv
package serial_majority_pkg;

    localparam int unsigned SMAJ_WORD_BITS = 13;
    localparam int unsigned SMAJ_CNT_W     = $clog2(SMAJ_WORD_BITS + 1);
    localparam int unsigned SMAJ_THRESHOLD = SMAJ_WORD_BITS / 2;

    typedef logic [SMAJ_CNT_W-1:0] smaj_cnt_t;

    typedef struct packed {
        smaj_cnt_t pos;
        logic      full;
    } smaj_pos_state_t;

    typedef struct packed {
        smaj_cnt_t ones;
    } smaj_ones_state_t;

endpackage

// File: rtl/smaj_pos_ctr.sv
module smaj_pos_ctr
    import serial_majority_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output smaj_cnt_t pos_o,
    output logic      full_o
);

    localparam smaj_cnt_t LAST_POS = smaj_cnt_t'(SMAJ_WORD_BITS - 1);

    smaj_pos_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!start_i) begin
            st_d.pos  = '0;
            st_d.full = 1'b0;
        end else if (!st_q.full) begin
            st_d.pos  = st_q.pos + smaj_cnt_t'(1);
            st_d.full = (st_q.pos == LAST_POS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.pos;
    assign full_o = st_q.full;

    // R2: a clearing edge empties the position count
    a_r2_clear_pos: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (pos_o == '0 && !full_o));

    // R3: each accepted bit moves the position on by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !full_o) |=> (pos_o == $past(pos_o) + smaj_cnt_t'(1)));

    // R5: a full word stays full while start is held
    a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && full_o) |=> (full_o && $stable(pos_o)));

endmodule

// File: rtl/smaj_ones_ctr.sv
module smaj_ones_ctr
    import serial_majority_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      take_i,
    input  logic      bit_i,
    output smaj_cnt_t ones_o
);

    smaj_ones_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!start_i) begin
            st_d.ones = '0;
        end else if (take_i && bit_i) begin
            st_d.ones = st_q.ones + smaj_cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ones_o = st_q.ones;

    // R5: bits arriving after the word is complete leave the count alone
    a_r5_ignore_extra: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !take_i) |=> $stable(ones_o));

    // R8: a clearing edge drops every counted one
    a_r8_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (ones_o == '0));

endmodule

// File: rtl/serial_majority.sv
module serial_majority
    import serial_majority_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bit_i,
    output logic result_o,
    output logic valid_o
);

    localparam smaj_cnt_t THRESH = smaj_cnt_t'(SMAJ_THRESHOLD);

    smaj_cnt_t pos_w;
    smaj_cnt_t ones_w;
    logic      full_w;

    smaj_pos_ctr u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .pos_o   (pos_w),
        .full_o  (full_w)
    );

    smaj_ones_ctr u_ones (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .take_i  (!full_w),
        .bit_i   (bit_i),
        .ones_o  (ones_w)
    );

    always_comb begin
        valid_o  = full_w;
        result_o = full_w && (ones_w > THRESH);
    end

    // R4: the ones count can never exceed the number of accepted bits
    a_r4_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_w <= pos_w);

    // R5: the decision does not move once the word is complete
    a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start_i) |=> (valid_o && $stable(result_o)));

    // R6: no decision is shown before the word is complete
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !result_o);

endmodule

// File: tb/serial_majority_bench.sv
module serial_majority_bench;

    localparam int CLK_PERIOD = 20;
    localparam int NBITS      = 13;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic start_i;
    logic bit_i;
    logic result_o;
    logic valid_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_majority u_serial_majority (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .bit_i    (bit_i),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

    function automatic logic ref_vote(input logic [NBITS-1:0] w);
        return ($countones(w) > 6);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_gap(input int cycles, input logic junk);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            bit_i   = junk;
        end
        @(negedge clk);
        check("R2 valid after clear", valid_o, 1'b0);
        check("R6 result after clear", result_o, 1'b0);
    endtask

    // Streams a word LSB first, then extra bits with start still high.
    task automatic run_word(input logic [NBITS-1:0] w, input int extra, input logic extra_val);
        logic exp;
        exp = ref_vote(w);
        for (int i = 0; i < NBITS; i++) begin
            @(negedge clk);
            if (i == NBITS - 1) begin
                check("R3 valid low after 12 bits", valid_o, 1'b0);
                check("R6 result low before valid", result_o, 1'b0);
            end
            start_i = 1'b1;
            bit_i   = w[i];
        end
        @(negedge clk);
        check("R3 valid after 13 bits", valid_o, 1'b1);
        check("R4 R7 majority result", result_o, exp);
        for (int i = 0; i < extra; i++) begin
            bit_i = extra_val;
            @(negedge clk);
            check("R5 valid held", valid_o, 1'b1);
            check("R5 result held", result_o, exp);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n   = 1'b0;
        start_i = 1'b0;
        bit_i   = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", valid_o, 1'b0);
        check("R1 result in reset", result_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", valid_o, 1'b0);
        check("R1 result after release", result_o, 1'b0);

        run_word(13'h0000, 1, 1'b1);
        clear_gap(1, 1'b1);
        run_word(13'h1FFF, 2, 1'b0);
        clear_gap(1, 1'b0);
        // exactly six ones: extra ones after the word must not tip it (R5)
        run_word(13'b0000000111111, 4, 1'b1);
        clear_gap(1, 1'b1);
        // exactly seven ones, deciding one last (R4)
        run_word(13'b1000000111111, 2, 1'b0);
        clear_gap(1, 1'b1);
        // six ones, last bit zero
        run_word(13'b0111111000000, 1, 1'b1);
        // R8: junk ones during a long clear, then a six-one word
        clear_gap(5, 1'b1);
        run_word(13'b0101010101010, 0, 1'b0);
        clear_gap(1, 1'b0);
        run_word(13'b1010101010101, 0, 1'b0);
        clear_gap(1, 1'b1);

        for (int n = 0; n < 60; n++) begin
            logic [NBITS-1:0] w;
            w = NBITS'($urandom);
            run_word(w, int'($urandom_range(0, 3)), 1'($urandom));
            clear_gap(int'($urandom_range(1, 3)), 1'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule